// File: doc/BRIEF.md
# I2C Write-Transfer Master with Software Byte Handshake

This block is an I2C master that performs write transfers only. Software loads a slave address byte and a first data byte, then writes the control register to begin. The master issues a START, shifts out the address byte and checks for an acknowledge. It then raises event flags and holds SCL low until software answers.

Each further data byte is released by software clearing the byte-event flag. The master raises that flag again as soon as the new byte begins to shift, so software can load the following byte while the current one is on the wire. A force-stop bit ends the transfer with a STOP after the data byte in flight. A NACK from the slave ends it at once. A masked interrupt output reports any pending flag.

SCL and SDA are open-drain style: an output of 1 pulls the line low, and 0 releases it. One SCL period is 4*QTR system clocks.

Top module: `i2c_wr_master`

## Requirements
- R1: After reset both bus outputs are released, all registers read 0 and `irq` is 0.
- R2: The control register is at address 0. Bit 7 is the interrupt enable, bit 3 the data-path enable, bit 1 force stop and bit 0 the start request. Bits 6:4 and 2 read 0. A write is taken as a start only when it has both bit 0 and bit 3 set and the master is idle (0x89 starts; 0x81 and 0xF6 do not).
- R3: A transfer is a START followed by the byte in the address register (address 1, bits 7:1 the slave address, bit 0 the mode, 0 meaning write), sent MSB first, then one acknowledge clock. Data bytes follow in the same format, each taken from the data register (address 2).
- R4: After an acknowledged address byte, status bit 0 (address sent) and status bit 1 (byte event) are set together, and SCL is held low while bit 1 stays set.
- R5: Clearing status bit 1 while held loads the data register and starts that byte, and bit 1 is set again as it starts. If bit 1 is still set when an acknowledged data byte ends, SCL is held low. If it has already been cleared, the next byte follows with no pause.
- R6: If force stop is set when an acknowledged data byte ends, the master drives a STOP, sets status bit 2 (stop done), clears force stop and releases both lines. The address byte never triggers force stop.
- R7: A NACK on the address or on any data byte causes an immediate STOP. Status bit 3 (NACK) and bit 2 are then set in the same cycle.
- R8: The status register is at address 3 and bits 7:4 read 0. Writing 0 to a flag clears it, and writing 1 leaves it unchanged.
- R9: `irq` is the OR of status bits 3:0, gated by control bit 7.
- R10: SCL rises every 4*QTR clocks within a byte. SDA changes only while SCL is low, except at START and STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for both write and read |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
Suppose the handshake state goes wrong, for example the master stops waiting on the byte-event flag. The slave model would then see an extra byte or a missing stretch within one byte time, about 36*QTR clocks. A shifter or bit-count fault shows up as a wrong byte value or byte count at the following STOP. A wrong flag update shows up in the next status read or at `irq` one cycle after the event. Long random software delays make the master stretch SCL in some runs and not in others, and injected NACKs cover both the address byte and the data bytes.

// File: rtl/i2c_wr_master.sv
`timescale 1ns/1ps
module i2c_wr_master #(
  parameter int QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic       sda_in
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;
  localparam logic [2:0] S_IDLE = 3'd0, S_STA = 3'd1, S_BIT = 3'd2, S_WAIT = 3'd3, S_STP = 3'd4;

  logic          ie, den, fs, stg;
  logic [7:0]    sadr, txd, sh;
  logic [3:0]    stat;
  logic [2:0]    st;
  logic [CW-1:0] cnt;
  logic [1:0]    q;
  logic [3:0]    bitn;
  logic          is_data, ack_ok, nack_p;

  wire run    = (st == S_STA) || (st == S_BIT) || (st == S_STP);
  wire tick   = (cnt == CW'(QTR - 1));
  wire last_q = run && tick && (q == 2'd3);
  wire ctl_wr = reg_we && (reg_addr == 2'd0);
  wire sts_wr = reg_we && (reg_addr == 2'd3);

  assign scl_oe = (st == S_STA) ? q[1] :
                  (st == S_BIT || st == S_STP) ? ~q[1] : (st == S_WAIT);
  assign sda_oe = (st == S_STA) ? 1'b1 :
                  (st == S_BIT) ? (bitn != 4'd8) && !sh[7] :
                  (st == S_STP) ? (q == 2'd1) || (q == 2'd2) : 1'b0;
  assign irq    = ie && (|stat);

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {ie, 3'b000, den, 1'b0, fs, stg};
      2'd1:    reg_rdata = sadr;
      2'd2:    reg_rdata = txd;
      default: reg_rdata = {4'b0000, stat};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ie, den, fs, stg} <= '0;
      sadr <= '0; txd <= '0; sh <= '0; stat <= '0;
      st <= S_IDLE; cnt <= '0; q <= '0; bitn <= '0;
      is_data <= 1'b0; ack_ok <= 1'b0; nack_p <= 1'b0;
    end else begin
      if (ctl_wr) {ie, den, fs, stg} <= {reg_wdata[7], reg_wdata[3], reg_wdata[1], reg_wdata[0]};
      if (reg_we && reg_addr == 2'd1) sadr <= reg_wdata;
      if (reg_we && reg_addr == 2'd2) txd <= reg_wdata;
      if (sts_wr) stat <= stat & reg_wdata[3:0];

      if (run) begin
        if (tick) begin
          cnt <= '0;
          q   <= q + 2'd1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else begin
        cnt <= '0;
        q   <= '0;
      end

      case (st)
        S_IDLE:
          if (ctl_wr && reg_wdata[0] && reg_wdata[3]) begin
            st <= S_STA; sh <= sadr; bitn <= '0; is_data <= 1'b0; nack_p <= 1'b0;
          end
        S_STA:
          if (last_q) st <= S_BIT;
        S_BIT: begin
          if (tick && q == 2'd2) ack_ok <= ~sda_in;
          if (last_q) begin
            if (bitn != 4'd8) begin
              sh   <= {sh[6:0], 1'b0};
              bitn <= bitn + 4'd1;
            end else if (!ack_ok) begin
              nack_p <= 1'b1;
              st     <= S_STP;
            end else if (!is_data) begin
              stat[0] <= 1'b1;
              stat[1] <= 1'b1;
              st      <= S_WAIT;
            end else if (fs) begin
              st <= S_STP;
            end else begin
              st <= S_WAIT;
            end
          end
        end
        S_WAIT:
          if (!stat[1]) begin
            sh <= txd; bitn <= '0; is_data <= 1'b1; stat[1] <= 1'b1; st <= S_BIT;
          end
        S_STP:
          if (last_q) begin
            st      <= S_IDLE;
            stat[2] <= 1'b1;
            if (nack_p) stat[3] <= 1'b1;
            fs      <= 1'b0;
          end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_wr_master_chk.sv
`timescale 1ns/1ps
module i2c_wr_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [1:0] reg_addr,
  input logic       wdata7,
  input logic       irq,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [2:0] st,
  input logic [3:0] stat
);
  localparam logic [2:0] C_BIT = 3'd2, C_WAIT = 3'd3;

  AST_ADDR_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[0]) |-> stat[1]); // R4
  AST_HOLD_LOW: assert property (@(posedge clk) disable iff (!rst_n) (st == C_WAIT && stat[1]) |=> scl_oe); // R5
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[2]) |-> (!scl_oe && !sda_oe)); // R6
  AST_NACK_WITH_STOP: assert property (@(posedge clk) disable iff (!rst_n) $rose(stat[3]) |-> stat[2]); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n) $past(reg_we && reg_addr == 2'd0 && !wdata7) |-> !irq); // R9
  AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_BIT && $past(st) == C_BIT && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe)); // R10
endmodule

bind i2c_wr_master i2c_wr_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .wdata7(reg_wdata[7]),
  .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .st(st), .stat(stat)
);

// File: tb/tb_i2c_wr_master.sv
`timescale 1ns/1ps
module tb_i2c_wr_master;
  localparam int QTR = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq, scl_oe, sda_oe;
  logic s_drv = 1'b0;
  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | s_drv);

  i2c_wr_master #(.QTR(QTR)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int starts = 0, stops = 0, nbytes = 0, bitcnt = 0, byte_idx = 0, nack_at = -1;
  int cyc = 0, last_rise = 0, per_n = 0, per_err = 0;
  logic ackph = 1'b0, p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] shreg = '0;
  logic [7:0] rx [0:15];

  always @(negedge clk) begin
    cyc++;
    if (p_scl && scl_line && p_sda && !sda_line) begin
      starts++; bitcnt = 0; byte_idx = 0; ackph = 1'b0; s_drv = 1'b0;
    end else if (p_scl && scl_line && !p_sda && sda_line) begin
      stops++; bitcnt = 0; ackph = 1'b0;
    end else if (!p_scl && scl_line) begin
      if (bitcnt >= 1 && bitcnt <= 7) begin
        per_n++;
        if (cyc - last_rise != 4 * QTR) per_err++;
      end
      last_rise = cyc;
      if (bitcnt < 8) begin
        shreg = {shreg[6:0], sda_line};
        bitcnt++;
        if (bitcnt == 8 && nbytes < 16) begin rx[nbytes] = shreg; nbytes++; end
      end
    end else if (p_scl && !scl_line) begin
      if (bitcnt == 8 && !ackph) begin
        ackph = 1'b1; s_drv = (byte_idx != nack_at);
      end else if (ackph) begin
        ackph = 1'b0; s_drv = 1'b0; bitcnt = 0; byte_idx++;
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  function automatic logic [7:0] exp_ctrl(input logic [7:0] w);
    return w & 8'h8B;
  endfunction

  function automatic logic exp_irq(input logic ie, input logic [7:0] s);
    return ie && (s[3:0] != 4'h0);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; #1 v = reg_rdata;
  endtask

  task automatic wait_st(input logic [7:0] mask, output logic [7:0] v);
    int n = 0;
    v = '0;
    while (n < 4000) begin
      @(negedge clk); reg_addr = 2'd3; #1 v = reg_rdata;
      if ((v & mask) != 0) break;
      n++;
    end
    if (n >= 4000) chk(1'b0, "R5 status wait timeout", v, mask);
  endtask

  task automatic xfer(input int n, input int nk, input bit rnd_delay);
    logic [7:0] d [0:7];
    logic [7:0] v, a;
    int hb = 0;
    a = {7'($urandom()), 1'b0};
    for (int i = 0; i < n; i++) d[i] = 8'($urandom());
    nack_at = nk; nbytes = 0; starts = 0; stops = 0;
    wr(2'd3, 8'h00);
    wr(2'd1, a);
    wr(2'd2, d[0]);
    wr(2'd0, 8'h89);
    wait_st(8'h06, v);
    if (nk != 0) begin
      chk(v == 8'h03, "R4 status after address", v, 8'h03);
      chk(irq == exp_irq(1'b1, v), "R9 irq on address event", irq, 1);
      for (int k = 0; k < 40; k++) begin @(negedge clk); if (!scl_line == 1'b0) hb++; end
      chk(hb == 0, "R4 SCL held low while event set", hb, 0);
      chk(nbytes == 1, "R4 no data before release", nbytes, 1);
      wr(2'd0, 8'h88);
      if (n == 1) wr(2'd0, 8'h8A);
      wr(2'd3, 8'hFC);
      for (int i = 0; i < n; i++) begin
        if (i > 0) begin wr(2'd2, d[i]); wr(2'd3, 8'hFD); end
        wait_st(8'h06, v);
        if (v[2]) break;
        if (i == n - 1) begin
          if (n > 1) wr(2'd0, 8'h8A);
          break;
        end
        if (rnd_delay) begin
          int dl = int'($urandom() % 260);
          repeat (dl) @(negedge clk);
          if (dl >= 200 && nk < 0) begin
            chk(scl_line == 1'b0, "R5 stretch after data byte", scl_line, 0);
            chk(nbytes == i + 2, "R5 bytes while stretched", nbytes, i + 2);
          end
        end
      end
    end
    wait_st(8'h04, v);
    repeat (4) @(negedge clk);
    rd(2'd3, v);
    if (nk < 0) begin
      chk(v == 8'h06, "R6 status after forced stop", v, 8'h06);
      chk(nbytes == n + 1, "R3 byte count", nbytes, n + 1);
      chk(starts == 1 && stops == 1, "R6 one START one STOP", stops, 1);
      for (int i = 0; i < n && i + 1 < nbytes; i++)
        chk(rx[i + 1] == d[i], "R3 data byte", rx[i + 1], d[i]);
      rd(2'd0, v);
      chk(v == 8'h88, "R6 force stop self-clears", v, 8'h88);
    end else begin
      chk((v & 8'h0C) == 8'h0C, "R7 nack and stop flags", v, 8'h0C);
      chk(nbytes == nk + 1, "R7 stop right after nacked byte", nbytes, nk + 1);
      chk(stops == 1, "R7 one STOP", stops, 1);
    end
    chk(rx[0] == a, "R3 address byte", rx[0], a);
    chk(scl_line && sda_line, "R6 bus released", {scl_line, sda_line}, 3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk(v == 8'h00, "R1 control reset", v, 0);
    rd(2'd3, v); chk(v == 8'h00, "R1 status reset", v, 0);
    chk(!irq && !scl_oe && !sda_oe, "R1 outputs released", {irq, scl_oe, sda_oe}, 0);

    wr(2'd0, 8'hF6); rd(2'd0, v);
    chk(v == exp_ctrl(8'hF6), "R2 reserved bits read 0", v, exp_ctrl(8'hF6));
    wr(2'd0, 8'h81); rd(2'd0, v);
    chk(v == exp_ctrl(8'h81), "R2 control readback", v, exp_ctrl(8'h81));
    repeat (100) @(negedge clk);
    chk(starts == 0 && scl_line, "R2 no start without enable", starts, 0);
    wr(2'd0, 8'h00);

    xfer(1, -1, 1'b0);
    xfer(3, -1, 1'b0);

    wr(2'd3, 8'hFF); rd(2'd3, v);
    chk(v == 8'h06, "R8 writing ones has no effect", v, 8'h06);
    wr(2'd0, 8'h08);
    chk(irq == exp_irq(1'b0, 8'h06), "R9 irq masked", irq, 0);
    wr(2'd0, 8'h88);
    chk(irq == exp_irq(1'b1, 8'h06), "R9 irq unmasked", irq, 1);
    wr(2'd3, 8'hFB); rd(2'd3, v);
    chk(v == 8'h02, "R8 zero clears one flag", v, 8'h02);
    wr(2'd3, 8'h00); rd(2'd3, v);
    chk(v == 8'h00 && !irq, "R8 all flags cleared", v, 0);

    xfer(2, 0, 1'b0);
    xfer(3, 2, 1'b0);

    repeat (10) xfer(1 + int'($urandom() % 5), -1, 1'b1);
    repeat (3) begin
      int n = 2 + int'($urandom() % 3);
      xfer(n, int'($urandom() % (n + 1)), 1'b1);
    end

    chk(per_n > 0 && per_err == 0, "R10 SCL period within bytes", per_err, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule